// File: doc/BRIEF.md
# Control-Transfer Sequencer

This block settles the instruction pointer for every control-transfer instruction of a small 32-bit processor: unconditional jumps, eight conditional jumps, subroutine calls and returns. The decoder hands it one instruction at a time as a valid/ready transfer. The transfer carries the opcode, a register-select field, the absolute target taken from the instruction bytes, the value of the named register, the current instruction and stack pointers, and the zero, sign and overflow flags. The block answers with a one-cycle `done` pulse. The new instruction pointer and, where the stack moved, the new stack pointer with a write strobe are valid in that same cycle.

Jumps finish in the cycle after acceptance. A call pushes its return address through a 32-bit memory write port. A return pops the instruction pointer through a 32-bit memory read port. Both ports use a req/ack handshake. The stack grows toward lower addresses in 4-byte slots: a push first lowers the stack pointer and then writes there, and a pop reads at the stack pointer and then raises it.

The instruction input follows these back-pressure rules. `ins_ready` is high whenever no call or return is in progress. A transfer happens on a rising edge where both `ins_valid` and `ins_ready` are high. While a stack access is outstanding, `ins_ready` stays low and whatever is on the instruction input is not taken.

Top module: `ctl_xfer_seq`

## Requirements
- R1: After reset, `done`, `sp_we`, `mw_req` and `mr_req` are low and `ins_ready` is high.
- R2: Opcode 0x30 (jump to absolute target) and 0x31 (jump to register value) raise `done` in the cycle after acceptance. `nxt_ip` equals `ins_target` or `ins_regval` respectively, and `sp_we` stays low.
- R3: For opcodes 0x40–0x4F, bits [2:0] select the condition: 0 zero, 1 sign, 2 overflow, 3 less (sign differs from overflow), 4 greater (not zero and sign equals overflow), 5 not zero, 6 not sign, 7 not overflow. When the condition holds, `nxt_ip` is `ins_target` for 0x40–0x47 and `ins_regval` for 0x48–0x4F.
- R4: A conditional jump whose condition fails gives `nxt_ip` = `cur_ip` + 5 for 0x40–0x47 and `cur_ip` + 2 for 0x48–0x4F. Taken or not, `done` rises in the cycle after acceptance.
- R5: A call, either 0x23 (target `ins_target`, length 5) or 0x24 (target `ins_regval`, length 2), raises `mw_req` in the cycle after acceptance. `mw_addr` = `cur_sp` − 4 and `mw_data` = `cur_ip` + length. Request, address and data hold steady until `mw_ack`.
- R6: In the cycle after `mw_ack`, a call raises `done` and `sp_we`, with `nxt_ip` = call target and `nxt_sp` = `cur_sp` − 4. `mw_req` is then low.
- R7: Opcode 0x22 with `ins_rsel` = 4 is a return. It raises `mr_req` with `mr_addr` = `cur_sp`, held until `mr_ack`. In the cycle after `mr_ack`, `done` and `sp_we` are high, `nxt_ip` = `mr_data` sampled with the ack, and `nxt_sp` = `cur_sp` + 4.
- R8: `ins_ready` is low from the cycle after a call or return is accepted until the cycle in which its `done` is high. An instruction offered during that window is not taken and does not change `nxt_ip`.
- R9: Any other opcode, including 0x22 with `ins_rsel` ≠ 4, completes with `done` in the cycle after acceptance. `nxt_ip` = `cur_ip`, `sp_we` stays low and no memory request is made.
- R10: `done` is high for exactly one cycle per accepted instruction, and `mw_req` and `mr_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Sequencer can take an instruction |
| ins_opcode | input | 8 | Opcode byte |
| ins_rsel | input | 4 | Register-select field (4 selects the instruction pointer) |
| ins_target | input | 32 | Absolute target from the instruction |
| ins_regval | input | 32 | Value of the named register |
| cur_ip | input | 32 | Address of the instruction's first byte |
| cur_sp | input | 32 | Current stack pointer |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_o | input | 1 | Overflow flag |
| mw_req | output | 1 | Stack write request |
| mw_addr | output | 32 | Stack write address |
| mw_data | output | 32 | Return address being pushed |
| mw_ack | input | 1 | Stack write accepted |
| mr_req | output | 1 | Stack read request |
| mr_addr | output | 32 | Stack read address |
| mr_data | input | 32 | Read data, valid with `mr_ack` |
| mr_ack | input | 1 | Stack read complete |
| done | output | 1 | Instruction complete, one-cycle pulse |
| nxt_ip | output | 32 | Next instruction pointer, valid with `done` |
| nxt_sp | output | 32 | Updated stack pointer, valid with `sp_we` |
| sp_we | output | 1 | Stack pointer update strobe |

## Verification
The assertions watch the handshake rules on every cycle. They check that a pending memory request keeps its address and data until acknowledged, that the two ports are never requested together, that input readiness is withdrawn while the stack is busy, and that an acknowledged push or pop completes in the next cycle with the stack pointer moved by one slot and the popped word in the instruction pointer. Whether each condition code is decoded correctly, and whether fall-through lengths and return addresses are right, only shows up in the bench's sweep over every condition, every flag combination and both target forms. The same holds for calls and returns under several acknowledge delays, and for instructions offered while the stack is busy.

// File: rtl/ctl_xfer_pkg.sv
package ctl_xfer_pkg;
  typedef enum logic [2:0] {
    XK_NONE,
    XK_JMP,
    XK_JCC,
    XK_CALL,
    XK_RET
  } xfer_kind_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_PUSH,
    SQ_POP
  } seq_state_t;

  localparam logic [7:0] OP_JMP_ABS  = 8'h30;
  localparam logic [7:0] OP_JMP_REG  = 8'h31;
  localparam logic [7:0] OP_CALL_ABS = 8'h23;
  localparam logic [7:0] OP_CALL_REG = 8'h24;
  localparam logic [7:0] OP_POP      = 8'h22;
  localparam logic [4:0] OP_JCC_ABS_HI = 5'b01000;
  localparam logic [4:0] OP_JCC_REG_HI = 5'b01001;
  localparam logic [3:0] RSEL_IP     = 4'd4;
  localparam int LEN_LONG  = 5;
  localparam int LEN_SHORT = 2;
endpackage

// File: rtl/cxs_decode.sv
module cxs_decode
  import ctl_xfer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [7:0]    opcode,
  input  logic [3:0]    rsel,
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] regval,
  output xfer_kind_t    kind,
  output logic [AW-1:0] dest,
  output logic [2:0]    ilen
);
  always_comb begin
    kind = XK_NONE;
    dest = target;
    ilen = 3'd0;
    if (opcode == OP_JMP_ABS) begin
      kind = XK_JMP;
      ilen = 3'(LEN_LONG);
    end else if (opcode == OP_JMP_REG) begin
      kind = XK_JMP;
      dest = regval;
      ilen = 3'(LEN_SHORT);
    end else if (opcode[7:3] == OP_JCC_ABS_HI) begin
      kind = XK_JCC;
      ilen = 3'(LEN_LONG);
    end else if (opcode[7:3] == OP_JCC_REG_HI) begin
      kind = XK_JCC;
      dest = regval;
      ilen = 3'(LEN_SHORT);
    end else if (opcode == OP_CALL_ABS) begin
      kind = XK_CALL;
      ilen = 3'(LEN_LONG);
    end else if (opcode == OP_CALL_REG) begin
      kind = XK_CALL;
      dest = regval;
      ilen = 3'(LEN_SHORT);
    end else if (opcode == OP_POP && rsel == RSEL_IP) begin
      kind = XK_RET;
      ilen = 3'(LEN_SHORT);
    end
  end
endmodule

// File: rtl/cxs_cond_eval.sv
module cxs_cond_eval (
  input  logic [2:0] csel,
  input  logic       fz,
  input  logic       fs,
  input  logic       fo,
  output logic       take
);
  logic less;
  assign less = fs ^ fo;

  always_comb begin
    unique case (csel)
      3'd0: take = fz;
      3'd1: take = fs;
      3'd2: take = fo;
      3'd3: take = less;
      3'd4: take = !fz && !less;
      3'd5: take = !fz;
      3'd6: take = !fs;
      default: take = !fo;
    endcase
  end
endmodule

// File: rtl/ctl_xfer_seq.sv
module ctl_xfer_seq
  import ctl_xfer_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SLOT_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [7:0]    ins_opcode,
  input  logic [3:0]    ins_rsel,
  input  logic [AW-1:0] ins_target,
  input  logic [AW-1:0] ins_regval,
  input  logic [AW-1:0] cur_ip,
  input  logic [AW-1:0] cur_sp,
  input  logic          flag_z,
  input  logic          flag_s,
  input  logic          flag_o,
  output logic          mw_req,
  output logic [AW-1:0] mw_addr,
  output logic [AW-1:0] mw_data,
  input  logic          mw_ack,
  output logic          mr_req,
  output logic [AW-1:0] mr_addr,
  input  logic [AW-1:0] mr_data,
  input  logic          mr_ack,
  output logic          done,
  output logic [AW-1:0] nxt_ip,
  output logic [AW-1:0] nxt_sp,
  output logic          sp_we
);
  localparam logic [AW-1:0] SLOT = AW'(SLOT_BYTES);

  seq_state_t    st_q;
  xfer_kind_t    kind;
  logic [AW-1:0] dest;
  logic [2:0]    ilen;
  logic          take;
  logic [AW-1:0] dest_q;
  logic [AW-1:0] sp_q;
  logic          accept;
  logic [AW-1:0] fall_ip;

  cxs_decode #(.AW(AW)) u_dec (
    .opcode (ins_opcode),
    .rsel   (ins_rsel),
    .target (ins_target),
    .regval (ins_regval),
    .kind   (kind),
    .dest   (dest),
    .ilen   (ilen)
  );

  cxs_cond_eval u_cond (
    .csel (ins_opcode[2:0]),
    .fz   (flag_z),
    .fs   (flag_s),
    .fo   (flag_o),
    .take (take)
  );

  assign ins_ready = (st_q == SQ_IDLE);
  assign accept    = ins_valid && ins_ready;
  assign fall_ip   = cur_ip + AW'(ilen);
  assign mw_req    = (st_q == SQ_PUSH);
  assign mr_req    = (st_q == SQ_POP);
  assign mr_addr   = sp_q;
  assign mw_addr   = sp_q - SLOT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      done    <= 1'b0;
      sp_we   <= 1'b0;
      nxt_ip  <= '0;
      nxt_sp  <= '0;
      dest_q  <= '0;
      sp_q    <= '0;
      mw_data <= '0;
    end else begin
      done  <= 1'b0;
      sp_we <= 1'b0;
      unique case (st_q)
        SQ_IDLE: begin
          if (accept) begin
            dest_q  <= dest;
            sp_q    <= cur_sp;
            mw_data <= fall_ip;
            unique case (kind)
              XK_JMP: begin
                done   <= 1'b1;
                nxt_ip <= dest;
              end
              XK_JCC: begin
                done   <= 1'b1;
                nxt_ip <= take ? dest : fall_ip;
              end
              XK_CALL: st_q <= SQ_PUSH;
              XK_RET:  st_q <= SQ_POP;
              default: begin
                done   <= 1'b1;
                nxt_ip <= cur_ip;
              end
            endcase
          end
        end
        SQ_PUSH: begin
          if (mw_ack) begin
            st_q   <= SQ_IDLE;
            done   <= 1'b1;
            sp_we  <= 1'b1;
            nxt_ip <= dest_q;
            nxt_sp <= sp_q - SLOT;
          end
        end
        default: begin
          if (mr_ack) begin
            st_q   <= SQ_IDLE;
            done   <= 1'b1;
            sp_we  <= 1'b1;
            nxt_ip <= mr_data;
            nxt_sp <= sp_q + SLOT;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ctl_xfer_seq_chk.sv
module ctl_xfer_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ins_valid,
  input logic          ins_ready,
  input logic          mw_req,
  input logic [AW-1:0] mw_addr,
  input logic [AW-1:0] mw_data,
  input logic          mw_ack,
  input logic          mr_req,
  input logic [AW-1:0] mr_addr,
  input logic [AW-1:0] mr_data,
  input logic          mr_ack,
  input logic          done,
  input logic [AW-1:0] nxt_ip,
  input logic [AW-1:0] nxt_sp,
  input logic          sp_we
);
  // R10
  excl_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mw_req && mr_req));

  // R5
  push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mw_req && !mw_ack |=> mw_req && $stable(mw_addr) && $stable(mw_data));

  // R7
  pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mr_req && !mr_ack |=> mr_req && $stable(mr_addr));

  // R6
  push_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mw_req && mw_ack |=> done && sp_we && !mw_req && nxt_sp == $past(mw_addr));

  // R7
  pop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mr_req && mr_ack |=> done && sp_we && nxt_ip == $past(mr_data)
                         && nxt_sp == $past(mr_addr) + AW'(4));

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_req || mr_req) |-> !ins_ready);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(ins_valid && ins_ready));

  // R10
  sp_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> done);
endmodule

bind ctl_xfer_seq ctl_xfer_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ins_valid (ins_valid),
  .ins_ready (ins_ready),
  .mw_req    (mw_req),
  .mw_addr   (mw_addr),
  .mw_data   (mw_data),
  .mw_ack    (mw_ack),
  .mr_req    (mr_req),
  .mr_addr   (mr_addr),
  .mr_data   (mr_data),
  .mr_ack    (mr_ack),
  .done      (done),
  .nxt_ip    (nxt_ip),
  .nxt_sp    (nxt_sp),
  .sp_we     (sp_we)
);

// File: tb/ctl_xfer_seq_bench.sv
module ctl_xfer_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [7:0]  ins_opcode = '0;
  logic [3:0]  ins_rsel = '0;
  logic [31:0] ins_target = '0, ins_regval = '0, cur_ip = '0, cur_sp = '0;
  logic        flag_z = 1'b0, flag_s = 1'b0, flag_o = 1'b0;
  logic        mw_req, mw_ack = 1'b0, mr_req, mr_ack = 1'b0;
  logic [31:0] mw_addr, mw_data, mr_addr, mr_data = '0;
  logic        done, sp_we;
  logic [31:0] nxt_ip, nxt_sp;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_xfer_seq u_ctl_xfer_seq (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_opcode(ins_opcode), .ins_rsel(ins_rsel), .ins_target(ins_target),
    .ins_regval(ins_regval), .cur_ip(cur_ip), .cur_sp(cur_sp),
    .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o),
    .mw_req(mw_req), .mw_addr(mw_addr), .mw_data(mw_data), .mw_ack(mw_ack),
    .mr_req(mr_req), .mr_addr(mr_addr), .mr_data(mr_data), .mr_ack(mr_ack),
    .done(done), .nxt_ip(nxt_ip), .nxt_sp(nxt_sp), .sp_we(sp_we)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit cond_holds(input int c, input bit z, input bit s, input bit o);
    case (c)
      0: return z;
      1: return s;
      2: return o;
      3: return s != o;
      4: return !z && (s == o);
      5: return !z;
      6: return !s;
      default: return !o;
    endcase
  endfunction

  task automatic issue(input logic [7:0] op, input logic [3:0] rs,
                       input logic [31:0] tg, input logic [31:0] rv,
                       input logic [31:0] ip, input logic [31:0] sp,
                       input bit z, input bit s, input bit o);
    @(negedge clk);
    ins_opcode = op; ins_rsel = rs; ins_target = tg; ins_regval = rv;
    cur_ip = ip; cur_sp = sp; flag_z = z; flag_s = s; flag_o = o;
    ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic one_cycle(input string req, input logic [31:0] exp_ip);
    chk({req, " done"}, 32'(done), 32'd1);
    chk({req, " nxt_ip"}, nxt_ip, exp_ip);
    chk({req, " sp_we"}, 32'(sp_we), 32'd0);
    chk({req, " no mem req"}, 32'(mw_req | mr_req), 32'd0);
    @(negedge clk);
    chk("R10 done pulse", 32'(done), 32'd0);
  endtask

  task automatic do_call(input logic [7:0] op, input logic [31:0] ip,
                         input logic [31:0] sp, input int dly);
    logic [31:0] tg, rv, exp_tgt, exp_ret;
    tg = 32'h0001_0000 + ip; rv = 32'h0002_0000 + sp;
    exp_tgt = (op == 8'h23) ? tg : rv;
    exp_ret = ip + ((op == 8'h23) ? 32'd5 : 32'd2);
    issue(op, 4'd0, tg, rv, ip, sp, 1'b0, 1'b0, 1'b0);
    chk("R5 mw_req", 32'(mw_req), 32'd1);
    chk("R5 mw_addr", mw_addr, sp - 32'd4);
    chk("R5 mw_data", mw_data, exp_ret);
    chk("R8 ready low", 32'(ins_ready), 32'd0);
    ins_opcode = 8'h30; ins_target = 32'hDEAD_0000; ins_valid = 1'b1;
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk("R5 req held", 32'(mw_req), 32'd1);
      chk("R5 addr held", mw_addr, sp - 32'd4);
      chk("R8 ready low", 32'(ins_ready), 32'd0);
    end
    mw_ack = 1'b1;
    @(negedge clk);
    mw_ack = 1'b0; ins_valid = 1'b0;
    chk("R6 done", 32'(done), 32'd1);
    chk("R6 sp_we", 32'(sp_we), 32'd1);
    chk("R6 nxt_ip", nxt_ip, exp_tgt);
    chk("R6 nxt_sp", nxt_sp, sp - 32'd4);
    chk("R6 req dropped", 32'(mw_req), 32'd0);
    @(negedge clk);
    chk("R8 offered jump not taken", 32'(done), 32'd0);
    chk("R8 nxt_ip kept", nxt_ip, exp_tgt);
  endtask

  task automatic do_ret(input logic [31:0] sp, input logic [31:0] word, input int dly);
    issue(8'h22, 4'd4, 32'h0, 32'h0, 32'h100, sp, 1'b0, 1'b0, 1'b0);
    chk("R7 mr_req", 32'(mr_req), 32'd1);
    chk("R7 mr_addr", mr_addr, sp);
    chk("R10 exclusive", 32'(mw_req), 32'd0);
    chk("R8 ready low", 32'(ins_ready), 32'd0);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk("R7 req held", 32'(mr_req), 32'd1);
    end
    mr_ack = 1'b1; mr_data = word;
    @(negedge clk);
    mr_ack = 1'b0; mr_data = 32'h0;
    chk("R7 done", 32'(done), 32'd1);
    chk("R7 sp_we", 32'(sp_we), 32'd1);
    chk("R7 nxt_ip", nxt_ip, word);
    chk("R7 nxt_sp", nxt_sp, sp + 32'd4);
    @(negedge clk);
    chk("R10 done pulse", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 sp_we", 32'(sp_we), 32'd0);
    chk("R1 mem req", 32'(mw_req | mr_req), 32'd0);
    chk("R1 ready", 32'(ins_ready), 32'd1);
    rst_n = 1'b1;

    // R2 unconditional jumps
    issue(8'h30, 4'd0, 32'h0000_4000, 32'h0000_7777, 32'h10, 32'h800, 1'b0, 1'b0, 1'b0);
    one_cycle("R2 jmp abs", 32'h0000_4000);
    issue(8'h31, 4'd1, 32'h0000_4000, 32'h0000_7777, 32'h10, 32'h800, 1'b1, 1'b1, 1'b1);
    one_cycle("R2 jmp reg", 32'h0000_7777);

    // R3 / R4 sweep: both forms, all conditions, all flag settings
    for (int form = 0; form < 2; form++)
      for (int c = 0; c < 8; c++)
        for (int fl = 0; fl < 8; fl++) begin
          logic [31:0] ip, tg, rv, exp_ip;
          bit tk;
          ip = 32'h0000_1000 + 32'(c * 64 + fl * 8 + form);
          tg = 32'h0003_0000 + 32'(c);
          rv = 32'h0005_0000 + 32'(fl);
          tk = cond_holds(c, fl[0], fl[1], fl[2]);
          if (tk) exp_ip = (form == 0) ? tg : rv;
          else    exp_ip = ip + ((form == 0) ? 32'd5 : 32'd2);
          issue(8'h40 + 8'(form * 8 + c), 4'd2, tg, rv, ip, 32'h900,
                fl[0], fl[1], fl[2]);
          one_cycle(tk ? "R3 jcc taken" : "R4 jcc fall", exp_ip);
        end

    // R5 / R6 calls with several ack delays
    do_call(8'h23, 32'h0000_2000, 32'h0000_8000, 0);
    do_call(8'h24, 32'h0000_2100, 32'h0000_7FFC, 1);
    do_call(8'h23, 32'hFFFF_FFFD, 32'h0000_0004, 3);
    do_call(8'h24, 32'h0000_3000, 32'h0000_0000, 5);

    // R7 returns
    do_ret(32'h0000_7FF8, 32'h0000_2005, 0);
    do_ret(32'h0000_7FFC, 32'hABCD_1234, 2);
    do_ret(32'hFFFF_FFFC, 32'h0000_0042, 4);

    // R9 other opcodes
    issue(8'h22, 4'd0, 32'h1, 32'h2, 32'h0000_5550, 32'h400, 1'b0, 1'b0, 1'b0);
    one_cycle("R9 pop non-ip", 32'h0000_5550);
    issue(8'h90, 4'd4, 32'h1, 32'h2, 32'h0000_5551, 32'h400, 1'b1, 1'b0, 1'b0);
    one_cycle("R9 nop", 32'h0000_5551);
    issue(8'h50, 4'd0, 32'h1, 32'h2, 32'h0000_5552, 32'h400, 1'b0, 1'b0, 1'b0);
    one_cycle("R9 out", 32'h0000_5552);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule